// File: doc/BRIEF.md
# Auxiliary TAP Handoff Controller

This block sits beside a primary JTAG controller. It lets that controller lend its test pins to one of up to four auxiliary TAP controllers, such as on-chip debug units. The primary instruction decoder pulses `start` and presents an index on `sel`, on the TCK edge that completes the load of an access instruction. From the next edge onward, pin TMS and TDI go to the chosen auxiliary TAP, and that TAP's TDO goes out on the pin. The `handoff_active` output tells the primary controller to keep its own TDO off the pin.

The primary controller is out of the loop during a handoff, so the block runs its own copy of the sixteen-state TAP sequence from pin TMS. This copy decides when control returns. Control returns when a data-register scan reaches Update-DR after passing through Pause-DR. It also returns when the TAP enters Test-Logic-Reset, or when the asynchronous test reset is asserted. Every auxiliary TAP that is not selected sees TMS low and TDI high, which holds it in Run-Test/Idle.

Top module: `aux_tap_handoff`

## Requirements
- R1: While `trst_n` is low and after it is released, `handoff_active` is 0, every `aux_tms` bit is 0, every `aux_tdi` bit is 1, and `tdo` follows `prim_tdo`.
- R2: When no handoff is active, `start` high at a rising TCK edge begins a handoff from that edge, and `sel` is latched as the auxiliary index. Index value k selects `aux_*[k]`.
- R3: During a handoff, `aux_tms[k]` and `aux_tdi[k]` of the selected lane k equal pin `tms` and `tdi` combinationally.
- R4: During a handoff, `tdo` equals `aux_tdo[k]` of the selected lane. Otherwise `tdo` equals `prim_tdo`.
- R5: Every lane that is not selected, and every lane when no handoff is active, has `aux_tms`=0 and `aux_tdi`=1.
- R6: A handoff ends at the rising edge that moves the TAP into Update-DR, if Pause-DR was entered since the last Capture-DR.
- R7: Reaching Update-DR without having entered Pause-DR in that scan does not end the handoff. Passing through Pause-IR does not count as Pause-DR.
- R8: The edge that moves the TAP into Test-Logic-Reset ends a handoff. A `start` pulse on an edge that leads into Test-Logic-Reset is ignored.
- R9: `trst_n` low ends a handoff at once, with no TCK edge, and returns the shadow TAP to Test-Logic-Reset. After release, the block runs normally once two TCK rising edges have passed.
- R10: A `start` pulse during an active handoff is ignored. The latched index and the routing stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Test mode select from the pin |
| tdi | input | 1 | Test data in from the pin |
| prim_tdo | input | 1 | Serial output of the primary controller |
| sel | input | IDX_W | Auxiliary TAP index, sampled with `start` |
| start | input | 1 | Handoff request strobe from the instruction decoder |
| aux_tdo | input | NUM_AUX | Serial outputs of the auxiliary TAPs |
| tdo | output | 1 | Test data out toward the pin |
| handoff_active | output | 1 | High while an auxiliary TAP owns the port |
| aux_tms | output | NUM_AUX | Per-lane TMS to the auxiliary TAPs |
| aux_tdi | output | NUM_AUX | Per-lane TDI to the auxiliary TAPs |

## Verification
The bench walks the TAP through a data scan that reaches Update-DR without a pause, and through an instruction scan that pauses in Pause-IR. A design that released on any Update-DR, or on any pause state, would drop the handoff in the middle of the debugger's session. A data scan that pauses, goes back to Shift-DR and then updates must release on that Update-DR edge. A design that cleared its pause memory on re-entering Shift-DR would keep the port. The bench also sends `start` while a handoff is active, and while TMS is steering into Test-Logic-Reset. It changes the auxiliary TDO pattern so that relatching the index, or routing the wrong lane, shows up on `tdo`. An asynchronous `trst_n` in the middle of a handoff must drop the handoff without a clock edge.

// File: rtl/aux_tap_pkg.sv
package aux_tap_pkg;

  typedef enum logic [3:0] {
    ST_TLR    = 4'd0,
    ST_RTI    = 4'd1,
    ST_SEL_DR = 4'd2,
    ST_CAP_DR = 4'd3,
    ST_SHF_DR = 4'd4,
    ST_EX1_DR = 4'd5,
    ST_PAU_DR = 4'd6,
    ST_EX2_DR = 4'd7,
    ST_UPD_DR = 4'd8,
    ST_SEL_IR = 4'd9,
    ST_CAP_IR = 4'd10,
    ST_SHF_IR = 4'd11,
    ST_EX1_IR = 4'd12,
    ST_PAU_IR = 4'd13,
    ST_EX2_IR = 4'd14,
    ST_UPD_IR = 4'd15
  } tap_state_e;

  // One step of the standard TAP sequence for a given TMS value.
  function automatic tap_state_e tap_step(input tap_state_e cur, input logic m);
    tap_state_e n;
    case (cur)
      ST_TLR:    n = m ? ST_TLR    : ST_RTI;
      ST_RTI:    n = m ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: n = m ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: n = m ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: n = m ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: n = m ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: n = m ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: n = m ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: n = m ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: n = m ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: n = m ? ST_SEL_DR : ST_RTI;
      default:   n = ST_TLR;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/aux_tap_rst_sync.sv
// Asserts asynchronously, releases after STAGES rising edges of clk.
module aux_tap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/aux_tap_shadow.sv
// Shadow copy of the TAP sequence, advanced by pin TMS.
module aux_tap_shadow
  import aux_tap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state_o,
  output tap_state_e state_nxt_o
);

  tap_state_e state_q;
  tap_state_e state_d;

  always_comb begin
    state_d = tap_step(state_q, tms);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_TLR;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o     = state_q;
  assign state_nxt_o = state_d;

endmodule

// File: rtl/aux_tap_grant.sv
// Ownership of the port: start, release on paused update, release on reset.
module aux_tap_grant
  import aux_tap_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] sel,
  input  tap_state_e       state_nxt,
  output logic             active_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             paused_o
);

  logic             act_q, act_d, act_en;
  logic [IDX_W-1:0] idx_q, idx_d, idx_en;
  logic             ps_q, ps_d, ps_en;
  logic             take, drop_tlr, drop_upd;

  always_comb begin
    take     = !act_q && start && (state_nxt != ST_TLR);
    drop_tlr = act_q && (state_nxt == ST_TLR);
    drop_upd = act_q && (state_nxt == ST_UPD_DR) && ps_q;

    act_en = take | drop_tlr | drop_upd;
    act_d  = take;

    idx_en = {IDX_W{take}};
    idx_d  = sel;

    ps_en = take | (state_nxt == ST_PAU_DR) | (state_nxt == ST_CAP_DR);
    if (take) begin
      ps_d = 1'b0;
    end else begin
      ps_d = (state_nxt == ST_PAU_DR);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
    end else if (act_en) begin
      act_q <= act_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (|idx_en) begin
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q <= 1'b0;
    end else if (ps_en) begin
      ps_q <= ps_d;
    end
  end

  assign active_o = act_q;
  assign idx_o    = idx_q;
  assign paused_o = ps_q;

endmodule

// File: rtl/aux_tap_route.sv
// Per-lane pin steering and TDO return multiplexer.
module aux_tap_route #(
  parameter int NUM_AUX = 4,
  parameter int IDX_W   = 2
) (
  input  logic               active,
  input  logic [IDX_W-1:0]   idx,
  input  logic               tms,
  input  logic               tdi,
  input  logic               prim_tdo,
  input  logic [NUM_AUX-1:0] aux_tdo,
  output logic [NUM_AUX-1:0] aux_tms,
  output logic [NUM_AUX-1:0] aux_tdi,
  output logic               tdo
);

  logic [NUM_AUX-1:0] hit;

  for (genvar i = 0; i < NUM_AUX; i++) begin : g_lane
    always_comb begin
      hit[i]     = active && (idx == IDX_W'(i));
      aux_tms[i] = hit[i] ? tms : 1'b0;
      aux_tdi[i] = hit[i] ? tdi : 1'b1;
    end
  end

  always_comb begin
    if (active) begin
      tdo = |(aux_tdo & hit);
    end else begin
      tdo = prim_tdo;
    end
  end

endmodule

// File: rtl/aux_tap_handoff.sv
module aux_tap_handoff
  import aux_tap_pkg::*;
#(
  parameter int NUM_AUX = 4,
  parameter int IDX_W   = (NUM_AUX > 1) ? $clog2(NUM_AUX) : 1
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic               prim_tdo,
  input  logic [IDX_W-1:0]   sel,
  input  logic               start,
  input  logic [NUM_AUX-1:0] aux_tdo,
  output logic               tdo,
  output logic               handoff_active,
  output logic [NUM_AUX-1:0] aux_tms,
  output logic [NUM_AUX-1:0] aux_tdi
);

  localparam int SYNC_STAGES = 2;

  logic             rst_n_s;
  tap_state_e       state_q;
  tap_state_e       state_nxt;
  logic             act;
  logic [IDX_W-1:0] idx_q;
  logic             paused;

  aux_tap_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (tck),
    .arst_n  (trst_n),
    .rst_n_o (rst_n_s)
  );

  aux_tap_shadow u_shadow (
    .clk         (tck),
    .rst_n       (rst_n_s),
    .tms         (tms),
    .state_o     (state_q),
    .state_nxt_o (state_nxt)
  );

  aux_tap_grant #(.IDX_W(IDX_W)) u_grant (
    .clk       (tck),
    .rst_n     (rst_n_s),
    .start     (start),
    .sel       (sel),
    .state_nxt (state_nxt),
    .active_o  (act),
    .idx_o     (idx_q),
    .paused_o  (paused)
  );

  aux_tap_route #(.NUM_AUX(NUM_AUX), .IDX_W(IDX_W)) u_route (
    .active   (act),
    .idx      (idx_q),
    .tms      (tms),
    .tdi      (tdi),
    .prim_tdo (prim_tdo),
    .aux_tdo  (aux_tdo),
    .aux_tms  (aux_tms),
    .aux_tdi  (aux_tdi),
    .tdo      (tdo)
  );

  assign handoff_active = act;

endmodule

// File: rtl/aux_tap_handoff_chk.sv
module aux_tap_handoff_chk
  import aux_tap_pkg::*;
#(
  parameter int NUM_AUX = 4,
  parameter int IDX_W   = 2
) (
  input logic               tck,
  input logic               rst_n,
  input logic               tms,
  input logic               start,
  input logic               prim_tdo,
  input logic               tdo,
  input logic               act,
  input logic [IDX_W-1:0]   idx,
  input logic               paused,
  input logic [3:0]         state,
  input logic [NUM_AUX-1:0] aux_tms,
  input logic [NUM_AUX-1:0] aux_tdi
);

  p_onehot_r3: assert property (@(posedge tck) disable iff (!rst_n)
    $onehot0(aux_tms));

  p_tdo_prim_r4: assert property (@(posedge tck) disable iff (!rst_n)
    !act |-> (tdo == prim_tdo));

  p_park_r5: assert property (@(posedge tck) disable iff (!rst_n)
    !act |-> (aux_tms == '0 && aux_tdi == '1));

  p_release_r6: assert property (@(posedge tck) disable iff (!rst_n)
    (act && state == 4'(ST_EX2_DR) && tms) |=> !act);

  p_keep_r7: assert property (@(posedge tck) disable iff (!rst_n)
    (act && state == 4'(ST_EX1_DR) && tms && !paused) |=> act);

  p_tlr_idle_r8: assert property (@(posedge tck) disable iff (!rst_n)
    (state == 4'(ST_TLR)) |-> !act);

  p_hold_idx_r10: assert property (@(posedge tck) disable iff (!rst_n)
    (act && start) |=> $stable(idx));

endmodule

bind aux_tap_handoff aux_tap_handoff_chk #(.NUM_AUX(NUM_AUX), .IDX_W(IDX_W)) u_chk (
  .tck      (tck),
  .rst_n    (rst_n_s),
  .tms      (tms),
  .start    (start),
  .prim_tdo (prim_tdo),
  .tdo      (tdo),
  .act      (handoff_active),
  .idx      (idx_q),
  .paused   (paused),
  .state    (state_q),
  .aux_tms  (aux_tms),
  .aux_tdi  (aux_tdi)
);

// File: tb/sim_aux_tap_handoff.sv
module sim_aux_tap_handoff;

  localparam int TLR = 0, RTI = 1, SDR = 2, CDR = 3, SHD = 4, E1D = 5, PDR = 6, E2D = 7,
                 UDR = 8, SIR = 9, CIR = 10, SHI = 11, E1I = 12, PIR = 13, E2I = 14, UIR = 15;

  typedef struct packed {
    logic       act;
    logic       tdo;
    logic [3:0] tms;
    logic [3:0] tdi;
  } obs_t;

  logic       tck;
  logic       trst_n, tms, tdi, prim_tdo, start;
  logic [1:0] sel;
  logic [3:0] aux_tdo;
  logic       tdo, handoff_active;
  logic [3:0] aux_tms, aux_tdi;

  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  obs_t exp_q[$];
  string tag_q[$];

  int         m_state;
  logic       m_act, m_ps;
  logic [1:0] m_idx;

  aux_tap_handoff u0 (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .prim_tdo(prim_tdo),
    .sel(sel), .start(start), .aux_tdo(aux_tdo), .tdo(tdo),
    .handoff_active(handoff_active), .aux_tms(aux_tms), .aux_tdi(aux_tdi)
  );

  initial tck = 1'b0;
  always #5 tck = ~tck;

  function automatic int tstep(input int s, input logic m);
    case (s)
      TLR: return m ? TLR : RTI;
      RTI: return m ? SDR : RTI;
      SDR: return m ? SIR : CDR;
      CDR: return m ? E1D : SHD;
      SHD: return m ? E1D : SHD;
      E1D: return m ? UDR : PDR;
      PDR: return m ? E2D : PDR;
      E2D: return m ? UDR : SHD;
      UDR: return m ? SDR : RTI;
      SIR: return m ? TLR : CIR;
      CIR: return m ? E1I : SHI;
      SHI: return m ? E1I : SHI;
      E1I: return m ? UIR : PIR;
      PIR: return m ? E2I : PIR;
      E2I: return m ? UIR : SHI;
      default: return m ? SDR : RTI;
    endcase
  endfunction

  function automatic obs_t sample_obs();
    obs_t o;
    o.act = handoff_active; o.tdo = tdo; o.tms = aux_tms; o.tdi = aux_tdi;
    return o;
  endfunction

  task automatic check(input string tag, input obs_t got, input obs_t want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s: got act=%b tdo=%b tms=%b tdi=%b, expected act=%b tdo=%b tms=%b tdi=%b",
               tag, got.act, got.tdo, got.tms, got.tdi, want.act, want.tdo, want.tms, want.tdi);
    end
  endtask

  function automatic obs_t idle_obs(input logic p);
    obs_t o;
    o.act = 1'b0; o.tdo = p; o.tms = 4'b0000; o.tdi = 4'b1111;
    return o;
  endfunction

  // Driver: called at a falling edge; drives one TCK cycle and queues the expectation.
  task automatic step(input logic tms_v, input logic tdi_v, input logic st_v,
                      input logic [1:0] sel_v, input string tag);
    int   nxt;
    obs_t e;
    tms = tms_v; tdi = tdi_v; start = st_v; sel = sel_v;
    prim_tdo = ~(tms_v ^ tdi_v);
    nxt = tstep(m_state, tms_v);
    if (!m_act) begin
      if (st_v && nxt != TLR) begin m_act = 1'b1; m_idx = sel_v; m_ps = 1'b0; end
    end else if (nxt == TLR) begin
      m_act = 1'b0;
    end else if (nxt == UDR && m_ps) begin
      m_act = 1'b0;
    end
    if (nxt == PDR) m_ps = 1'b1;
    else if (nxt == CDR) m_ps = 1'b0;
    m_state = nxt;
    e.act = m_act;
    e.tdo = m_act ? aux_tdo[m_idx] : prim_tdo;
    for (int i = 0; i < 4; i++) begin
      e.tms[i] = (m_act && m_idx == 2'(i)) ? tms_v : 1'b0;
      e.tdi[i] = (m_act && m_idx == 2'(i)) ? tdi_v : 1'b1;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge tck);
  endtask

  // Monitor: pops one expectation per rising edge, 2 ns after it.
  always @(posedge tck) begin
    #2;
    if (exp_q.size() > 0) begin
      check(tag_q.pop_front(), sample_obs(), exp_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge tck);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got running, expected finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    trst_n = 1'b0; tms = 1'b1; tdi = 1'b1; start = 1'b0; sel = 2'd0;
    prim_tdo = 1'b0; aux_tdo = 4'b0100;
    m_state = TLR; m_act = 1'b0; m_ps = 1'b0; m_idx = 2'd0;
    repeat (2) @(negedge tck);
    #1 check("R1 reset", sample_obs(), idle_obs(1'b0));
    prim_tdo = 1'b1;
    #1 check("R1 reset tdo", sample_obs(), idle_obs(1'b1));
    @(negedge tck);
    trst_n = 1'b1;
    repeat (3) step(1, 1, 0, 0, "R1 after release");

    // Handoff to lane 2 from Run-Test/Idle.
    step(0, 1, 0, 0, "R5 idle");
    step(0, 1, 1, 2'd2, "R2 start lane2");
    step(1, 0, 0, 0, "R3 select-dr");
    step(0, 1, 0, 0, "R3 capture");
    step(0, 0, 0, 0, "R4 shift");
    aux_tdo = 4'b1011;
    step(0, 1, 0, 0, "R4 shift tdo0");
    step(1, 0, 0, 0, "R3 exit1");
    step(1, 1, 0, 0, "R7 update no pause");
    step(0, 0, 0, 0, "R7 still active");
    // Instruction scan with Pause-IR, then an unpaused data scan.
    step(1, 0, 0, 0, "R7 sdr");
    step(1, 1, 0, 0, "R7 sir");
    step(0, 0, 0, 0, "R7 cir");
    step(1, 1, 0, 0, "R7 e1i");
    step(0, 0, 0, 0, "R7 pause-ir");
    step(1, 1, 0, 0, "R7 e2i");
    step(1, 0, 0, 0, "R7 uir");
    step(1, 1, 0, 0, "R7 sdr2");
    step(0, 0, 0, 0, "R7 cdr");
    step(1, 1, 0, 0, "R7 e1d");
    step(1, 0, 0, 0, "R7 udr kept");
    // Start while active must not relatch.
    aux_tdo = 4'b0010;
    step(0, 1, 1, 2'd1, "R10 start ignored");
    step(0, 0, 1, 2'd3, "R10 start ignored again");
    aux_tdo = 4'b0100;
    // Paused scan: pause, back to shift, then update releases.
    step(1, 1, 0, 0, "R6 sdr");
    step(0, 0, 0, 0, "R6 cdr");
    step(0, 1, 0, 0, "R6 shift");
    step(1, 0, 0, 0, "R6 e1d");
    step(0, 1, 0, 0, "R6 pause");
    step(0, 0, 0, 0, "R6 pause hold");
    step(1, 1, 0, 0, "R6 e2d");
    step(0, 0, 0, 0, "R6 back to shift");
    step(1, 1, 0, 0, "R6 e1d again");
    step(1, 0, 0, 0, "R6 update releases");
    step(0, 1, 0, 0, "R5 parked");
    // Handoff to lane 1, then Test-Logic-Reset.
    step(0, 0, 1, 2'd1, "R2 start lane1");
    aux_tdo = 4'b1101;
    step(1, 1, 0, 0, "R4 lane1 tdo0");
    aux_tdo = 4'b0010;
    step(0, 0, 0, 0, "R4 lane1 tdo1");
    step(1, 1, 0, 0, "R8 e1d");
    step(1, 0, 0, 0, "R8 udr");
    step(1, 1, 0, 0, "R8 sdr");
    step(1, 0, 0, 0, "R8 sir");
    step(1, 1, 0, 0, "R8 enter tlr");
    step(1, 0, 1, 2'd3, "R8 start into tlr ignored");
    // Handoff to lane 3, then asynchronous reset.
    step(0, 1, 0, 0, "R5 rti");
    step(0, 1, 1, 2'd3, "R2 start lane3");
    aux_tdo = 4'b1000;
    step(1, 0, 0, 0, "R3 lane3 sdr");
    step(0, 1, 0, 0, "R4 lane3 cdr");
    tms = 1'b1; start = 1'b0;
    #1 trst_n = 1'b0;
    #1 check("R9 async reset", sample_obs(), idle_obs(prim_tdo));
    @(negedge tck);
    trst_n = 1'b1;
    m_state = TLR; m_act = 1'b0; m_ps = 1'b0; m_idx = 2'd0;
    step(1, 1, 0, 0, "R9 sync stage1");
    step(1, 1, 0, 0, "R9 sync stage2");
    step(0, 1, 0, 0, "R9 rti");
    step(0, 0, 1, 2'd0, "R9 start lane0 after reset");
    aux_tdo = 4'b0001;
    step(0, 1, 0, 0, "R9 lane0 tdo");
    @(posedge tck);
    #3;
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule